// File: doc/BRIEF.md
# Analytic Signal FIR Pair

This block turns one band-limited stream of signed 10-bit samples into an analytic signal with two outputs. The in-phase part is the input delayed to the centre of the filter window. The quadrature part is the output of a 33-tap antisymmetric FIR that approximates a Hilbert transform, which shifts every in-band component by 90 degrees. Both parts are taken from the same window of stored samples, so they leave the block on the same clock edge and describe the same instant. That instant is 16 accepted samples behind the newest input. The block is placed once per recording channel and feeds the phase and magnitude stages downstream.

A single-cycle enable marks each new sample. The nominal rate is 1 kS/s, which is far below the clock rate. Only the odd offsets from the window centre carry a non-zero coefficient, so there are eight coefficient pairs. A subtraction in front of the multiplier folds each pair into one term, and one shared multiplier works through the eight terms, one per clock. The sum is kept at full precision, then rounded and clipped to 10 bits. A one-cycle valid strobe comes with every result that was computed from a window holding only real samples.

Top module: `analytic_pair_fir`

## Requirements
- R1: While reset is asserted and after it is released, `realOut` and `imagOut` read 0 and `outValid` reads 0 until the first result is loaded.
- R2: Each result's `realOut` equals the sample accepted 16 enables before the newest accepted sample. While fewer than 17 samples have been accepted since reset, it reads 0.
- R3: Let w[i] be the sample accepted i enables before the newest one (w[0] is the newest), with w[i] = 0 before it exists. Let c1..c15 (odd k only) be 326, 109, 65, 47, 36, 30, 25, 22. The accumulator is S = sum over odd k of ck*(w[16+k] - w[16-k]), and `imagOut` = (S + 256) >>> 9, an arithmetic shift.
- R4: When the rounded value of R3 is above 511, `imagOut` is 511. When it is below -512, `imagOut` is -512.
- R5: `realOut` and `imagOut` take their new values at the 10th rising clock edge, counting the edge that accepts the enable as the first. They hold their values on every other edge.
- R6: `outValid` is high for exactly one cycle, the cycle in which a new result appears, and only once 33 samples have been accepted since reset. It is 0 at every other time.
- R7: An enable that arrives on any of the 9 clock edges after an accepted enable is ignored. It does not enter the window and does not trigger a new result.
- R8: Reset empties the sample window. After reset, stored samples from before the reset contribute nothing to later results, and `outValid` stays low again for the first 32 results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | One-cycle strobe marking a new input sample |
| sampleIn | input | 10 | Signed two's-complement input sample |
| realOut | output | 10 | Signed in-phase component (window centre) |
| imagOut | output | 10 | Signed quadrature component (Hilbert FIR output) |
| outValid | output | 1 | One-cycle strobe for a result from a full window |

## Verification
Every result is due exactly 10 rising edges after the edge that accepts its enable. The driver records that cycle number with the expected real, quadrature and valid values. The monitor compares them on the falling edge of that cycle, and on the falling edge just before it checks that both outputs still hold the previous result. The bench spaces enables 12 cycles apart, so each result settles before the next sample arrives. The ignored enables are placed 4 cycles after an accepted one, inside the 9-edge busy window. Outside the due cycles the monitor records any valid strobe as a stray pulse.

// File: rtl/asig_pkg.sv
package asig_pkg;

  // Width of the tap-pair select carried in the strobe bundle (up to 32 pairs)
  localparam int SEL_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             shiftEn;  // accept sample, shift window, clear sum
    logic             macEn;    // accumulate one folded tap pair
    logic [SEL_W-1:0] tapSel;   // which pair (offset 2*tapSel+1 from centre)
    logic             outLoad;  // register rounded result and centre sample
  } strobe_t;

  // Ideal Hilbert coefficient 2/(pi*k) scaled by 2^frac, rounded to nearest.
  // Integer arithmetic only, evaluated at elaboration.
  function automatic int hilbertCoef(int k, int frac);
    longint num;
    longint den;
    num = longint'(1) << (frac + 1);
    num = num * 64'sd1000000;
    den = 64'sd3141593 * longint'(k);
    return int'(((64'sd2 * num) / den + 64'sd1) / 64'sd2);
  endfunction

endpackage

// File: rtl/asig_ctrl.sv
module asig_ctrl
  import asig_pkg::*;
#(
  parameter int NUM_TAPS = 33
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleEn,
  output strobe_t strb,
  output logic    outValid
);

  localparam int CENTER = (NUM_TAPS - 1) / 2;
  localparam int NZ     = (CENTER + 1) / 2;
  localparam int CNT_W  = $clog2(NUM_TAPS + 1);

  seq_state_t       state;
  logic [SEL_W-1:0] tapIdx;
  logic [CNT_W-1:0] fillCnt;
  logic             lastTap;
  logic             windowFull;

  assign lastTap    = (tapIdx == SEL_W'(NZ - 1));
  assign windowFull = (fillCnt == CNT_W'(NUM_TAPS));

  always_comb begin
    strb.shiftEn = (state == ST_IDLE) && sampleEn;
    strb.macEn   = (state == ST_MAC);
    strb.tapSel  = tapIdx;
    strb.outLoad = (state == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tapIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sampleEn) begin
            state  <= ST_MAC;
            tapIdx <= '0;
          end
        end
        ST_MAC: begin
          if (lastTap) begin
            state <= ST_LOAD;
          end else begin
            tapIdx <= tapIdx + 1'b1;
          end
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.shiftEn && !windowFull) begin
        fillCnt <= fillCnt + 1'b1;
      end
      outValid <= strb.outLoad && windowFull;
    end
  end

  // R5
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> strb.macEn && (strb.tapSel == '0));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.macEn && !lastTap |=> strb.macEn && (strb.tapSel == $past(strb.tapSel) + 1'b1));

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MAC) && sampleEn |=> $stable(fillCnt));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6
  valid_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.outLoad) && windowFull);

endmodule

// File: rtl/asig_datapath.sv
module asig_datapath
  import asig_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int NUM_TAPS  = 33,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] realOut,
  output logic signed [DATA_W-1:0] imagOut
);

  localparam int CENTER = (NUM_TAPS - 1) / 2;
  localparam int NZ     = (CENTER + 1) / 2;
  localparam int DIFF_W = DATA_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NZ) + 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

  logic signed [DATA_W-1:0] win [NUM_TAPS];
  logic signed [COEF_W-1:0] coefTab [NZ];
  logic signed [DATA_W-1:0] olderTap;
  logic signed [DATA_W-1:0] newerTap;
  logic signed [COEF_W-1:0] coefSel;
  logic signed [DIFF_W-1:0] tapDiff;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  biased;
  logic signed [ACC_W-1:0]  shifted;
  logic signed [DATA_W-1:0] satVal;

  // Fixed coefficient per folded pair, offset 2g+1 from the centre
  for (genvar g = 0; g < NZ; g++) begin : g_coef
    assign coefTab[g] = COEF_W'(hilbertCoef(2 * g + 1, COEF_FRAC));
  end

  // Select the pair served by the shared multiplier this cycle
  always_comb begin
    olderTap = win[CENTER + 1];
    newerTap = win[CENTER - 1];
    coefSel  = coefTab[0];
    for (int i = 1; i < NZ; i++) begin
      if (strb.tapSel == SEL_W'(i)) begin
        olderTap = win[CENTER + 2 * i + 1];
        newerTap = win[CENTER - 2 * i - 1];
        coefSel  = coefTab[i];
      end
    end
  end

  assign tapDiff = {olderTap[DATA_W-1], olderTap} - {newerTap[DATA_W-1], newerTap};
  assign prod    = tapDiff * coefSel;

  // Round half up, then clip to the signed output range
  always_comb begin
    biased  = acc + HALF;
    shifted = biased >>> COEF_FRAC;
    if (shifted > MAXV) begin
      satVal = MAXV[DATA_W-1:0];
    end else if (shifted < MINV) begin
      satVal = MINV[DATA_W-1:0];
    end else begin
      satVal = shifted[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TAPS; i++) begin
        win[i] <= '0;
      end
    end else if (strb.shiftEn) begin
      win[0] <= sampleIn;
      for (int i = 1; i < NUM_TAPS; i++) begin
        win[i] <= win[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strb.shiftEn) begin
      acc <= '0;
    end else if (strb.macEn) begin
      acc <= acc + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      realOut <= '0;
      imagOut <= '0;
    end else if (strb.outLoad) begin
      realOut <= win[CENTER];
      imagOut <= satVal;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outLoad |=> $stable(realOut) && $stable(imagOut));

  // R7
  window_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(win[0]) && $stable(win[CENTER]));

  // R4
  clip_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad && (shifted > MAXV) |=> imagOut == MAXV[DATA_W-1:0]);

endmodule

// File: rtl/analytic_pair_fir.sv
module analytic_pair_fir
  import asig_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int NUM_TAPS  = 33,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleEn,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] realOut,
  output logic signed [DATA_W-1:0] imagOut,
  output logic                     outValid
);

  strobe_t strb;

  asig_ctrl #(
    .NUM_TAPS(NUM_TAPS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sampleEn(sampleEn),
    .strb    (strb),
    .outValid(outValid)
  );

  asig_datapath #(
    .DATA_W   (DATA_W),
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W),
    .COEF_FRAC(COEF_FRAC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sampleIn(sampleIn),
    .realOut (realOut),
    .imagOut (imagOut)
  );

endmodule

// File: tb/sim_analytic_pair_fir.sv
module sim_analytic_pair_fir;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleEn = 1'b0;
  logic signed [9:0] sampleIn = '0;
  logic signed [9:0] realOut;
  logic signed [9:0] imagOut;
  logic              outValid;

  always #10 clk = ~clk;

  analytic_pair_fir u0 (
    .clk     (clk),
    .rstN    (rstN),
    .sampleEn(sampleEn),
    .sampleIn(sampleIn),
    .realOut (realOut),
    .imagOut (imagOut),
    .outValid(outValid)
  );

  typedef struct {
    int    due;
    int    re;
    int    im;
    bit    vld;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   stray = 0;
  int   lastRe = 0;
  int   lastIm = 0;
  int   win[33];
  int   filled = 0;
  int   cTab[8] = '{326, 109, 65, 47, 36, 30, 25, 22};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic void modelClear();
    for (int i = 0; i < 33; i++) win[i] = 0;
    filled = 0;
  endfunction

  function automatic exp_t modelAccept(int x, string tag, int due);
    exp_t e;
    int s;
    int r;
    for (int i = 32; i > 0; i--) win[i] = win[i-1];
    win[0] = x;
    if (filled < 33) filled++;
    s = 0;
    for (int t = 0; t < 8; t++) s += cTab[t] * (win[16 + 2*t + 1] - win[16 - 2*t - 1]);
    r = (s + 256) >>> 9;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    e.due = due;
    e.re  = win[16];
    e.im  = r;
    e.vld = (filled == 33);
    e.tag = tag;
    return e;
  endfunction

  // Driver: one accepted sample, optionally followed by an enable inside the busy window
  task automatic send(int x, string tag, bit doDrop = 1'b0, int dropVal = 0);
    @(negedge clk);
    sampleIn = 10'(x);
    sampleEn = 1'b1;
    q.push_back(modelAccept(x, tag, cyc + 10));
    @(negedge clk);
    sampleEn = 1'b0;
    if (doDrop) begin
      repeat (3) @(negedge clk);
      sampleIn = 10'(dropVal);
      sampleEn = 1'b1;
      @(negedge clk);
      sampleEn = 1'b0;
      repeat (6) @(negedge clk);
    end else begin
      repeat (10) @(negedge clk);
    end
  endtask

  // Monitor: pops each expected item on its due cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (q.size() > 0 && q[0].due == cyc + 1) begin
        check("R5", "realOut held before due", int'(realOut), lastRe);
        check("R5", "imagOut held before due", int'(imagOut), lastIm);
        if (outValid) stray++;
      end else if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        string reTag;
        e = q.pop_front();
        reTag = (e.tag == "R3" || e.tag == "R4") ? "R2" : e.tag;
        check(reTag, "realOut", int'(realOut), e.re);
        check(e.tag, "imagOut", int'(imagOut), e.im);
        check("R6", "outValid", int'(outValid), int'(e.vld));
        lastRe = e.re;
        lastIm = e.im;
      end else if (outValid) begin
        stray++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    check("R1", "realOut in reset", int'(realOut), 0);
    check("R1", "imagOut in reset", int'(imagOut), 0);
    check("R1", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "realOut after reset", int'(realOut), 0);
    check("R1", "outValid after reset", int'(outValid), 0);

    // Impulse: exposes each coefficient and the fill point of the valid strobe
    send(256, "R3");
    for (int n = 0; n < 39; n++) send(0, "R3");

    // Sampled cosine, period 10 samples
    for (int n = 0; n < 40; n++)
      send($rtoi(400.0 * $cos(2.0 * 3.14159265 * real'(n) / 10.0)), "R3");

    // Full-scale steps drive the sum past both limits
    for (int n = 0; n < 20; n++) send(511, "R4");
    for (int n = 0; n < 20; n++) send(-512, "R4");
    for (int n = 0; n < 20; n++) send(511, "R4");

    // Enables inside the busy window must be dropped
    send(123, "R7", 1'b1, -400);
    send(-77, "R7");
    send(200, "R7", 1'b1, 350);
    for (int n = 0; n < 17; n++) send(5 * n - 30, "R7");

    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);

    // Reset in mid-stream clears the window and the fill count
    rstN = 1'b0;
    modelClear();
    lastRe = 0;
    lastIm = 0;
    @(negedge clk);
    check("R1", "realOut second reset", int'(realOut), 0);
    check("R1", "imagOut second reset", int'(imagOut), 0);
    rstN = 1'b1;
    for (int n = 0; n < 20; n++) send(20 * n - 200, "R8");

    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R6", "stray valid pulses", stray, 0);

    summary();
    $finish;
  end

endmodule